// File: doc/BRIEF.md
# Register Valid-Bit Interlock

This block is the hazard scoreboard for a small in-order pipeline. Each architectural register has one valid bit. A clear bit means that an instruction already in flight will write that register and has not yet done so. The decode stage presents one instruction at a time as an issue request. The request carries two source indices and one destination index. The block holds decode back with a stall until all three named registers are valid.

When an instruction leaves decode without a stall, its destination bit is cleared. The writeback stage later sets the bit again when it commits the result. The destination is checked together with the sources, so one set of bits keeps both read-after-write order and write-after-write order. A writeback that arrives in the same cycle as a decode is seen by that decode at once. Register 0 is a constant register and never becomes pending.

Top module: `reg_interlock`

## Requirements
- R1: After reset every bit of `valid_vec` is 1. Bit i of `valid_vec` is the valid bit of register i.
- R2: Bit 0 of `valid_vec` is always 1. An accepted issue whose destination is 0 leaves every bit unchanged.
- R3: With `iss_req` high, `stall` is 1 in the same cycle when the register named by `src_a` or by `src_b` is invalid.
- R4: With `iss_req` high, `stall` is 1 in the same cycle when the register named by `dst` is invalid, even when both sources are valid. This enforces write-after-write order.
- R5: An issue is accepted when `iss_req` is high and `stall` is low. An accepted issue clears the bit of `dst` at the next clock edge. A stalled issue changes no bit.
- R6: A cycle with `wb_en` high sets the bit of `wb_idx` at the next clock edge.
- R7: A writeback is visible to decode in its own cycle. A register being written back that cycle counts as valid for the stall decision.
- R8: An accepted issue and a writeback that name the same register in the same cycle leave that register's bit at 0.
- R9: `stall` is 0 whenever `iss_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_req | input | 1 | Decode presents an instruction |
| src_a | input | 4 | First source register index |
| src_b | input | 4 | Second source register index |
| dst | input | 4 | Destination register index |
| wb_en | input | 1 | Writeback strobe |
| wb_idx | input | 4 | Register index being written back |
| stall | output | 1 | Decode must hold this cycle |
| valid_vec | output | 16 | Registered valid bit per register |

## Verification
Directed patterns come first.
- A write to a register followed by a read of it must stall. This separates the source check from the destination check.
- A second write to a still-pending register must stall even though both of its sources are valid.
- A writeback in the same cycle as a dependent decode must release that decode at once. This separates the bypass from a one-cycle-late release.
- An issue and a writeback to the same register in the same cycle must leave the bit clear. This shows which update has priority.
- An issue whose destination is 0 must leave all bits unchanged.
- An idle decode that names pending registers must not stall.

A long pseudo-random stream then mixes issues and writebacks of pending registers. It is compared each cycle against a model that tracks the pending writes of every register.

// File: rtl/reg_interlock.sv
module reg_interlock #(
  parameter int NREG = 16,
  localparam int IW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            iss_req,
  input  logic [IW-1:0]   src_a,
  input  logic [IW-1:0]   src_b,
  input  logic [IW-1:0]   dst,
  input  logic            wb_en,
  input  logic [IW-1:0]   wb_idx,
  output logic            stall,
  output logic [NREG-1:0] valid_vec
);

  localparam logic [NREG-1:0] ONE = {{(NREG-1){1'b0}}, 1'b1};

  logic [NREG-1:0] vld_q, wb_hot, iss_hot, seen;
  logic            issue;

  assign wb_hot  = wb_en ? (ONE << wb_idx) : '0;
  assign seen    = vld_q | wb_hot;
  assign stall   = iss_req & ~(seen[src_a] & seen[src_b] & seen[dst]);
  assign issue   = iss_req & ~stall;
  assign iss_hot = (issue && dst != '0) ? (ONE << dst) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= '1;
    else        vld_q <= (seen & ~iss_hot) | ONE;
  end

  assign valid_vec = vld_q;

  p_zero_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_vec[0]);

  p_idle_no_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_req |-> !stall);

  p_src_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_req && !valid_vec[src_a] && !(wb_en && wb_idx == src_a)) |-> stall);

  p_dst_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_req && !valid_vec[dst] && !(wb_en && wb_idx == dst)) |-> stall);

  p_issue_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_req && !stall && dst != '0) |=> !valid_vec[$past(dst)]);

  p_wb_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && !(iss_req && !stall && dst == wb_idx)) |=> valid_vec[$past(wb_idx)]);

  p_stall_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !wb_en) |=> $stable(valid_vec));

endmodule

// File: tb/tb_reg_interlock.sv
module tb_reg_interlock;
  localparam int NREG = 16;

  logic clk = 0, rst_n = 0;
  logic iss_req = 0, wb_en = 0;
  logic [3:0] src_a = 0, src_b = 0, dst = 0, wb_idx = 0;
  logic stall;
  logic [NREG-1:0] valid_vec;

  int checks = 0, fails = 0;
  logic [NREG-1:0] model;

  typedef struct { logic [NREG-1:0] v; string tag; } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  reg_interlock dut (.*);

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (valid_vec !== e.v) begin
        fails++;
        $display("FAIL %s valid_vec actual %h expected %h", e.tag, valid_vec, e.v);
      end
    end
  end

  task automatic step(input logic rq, input logic [3:0] a, input logic [3:0] b,
                      input logic [3:0] d, input logic we, input logic [3:0] wi,
                      input string tag);
    logic [NREG-1:0] eff;
    logic es;
    exp_t e;
    @(negedge clk);
    iss_req = rq; src_a = a; src_b = b; dst = d; wb_en = we; wb_idx = wi;
    eff = model;
    if (we) eff[wi] = 1'b1;
    es = rq & ~(eff[a] & eff[b] & eff[d]);
    #1;
    checks++;
    if (stall !== es) begin
      fails++;
      $display("FAIL %s stall actual %b expected %b", tag, stall, es);
    end
    if (rq && !es && d != 0) eff[d] = 1'b0;
    eff[0] = 1'b1;
    model = eff;
    e.v = eff; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    model = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    checks++;
    if (valid_vec !== '1) begin
      fails++;
      $display("FAIL R1 reset valid_vec actual %h expected %h", valid_vec, {NREG{1'b1}});
    end
    step(1, 3, 4, 2, 0, 0, "R5 issue dst 2");
    step(1, 2, 1, 9, 0, 0, "R3 read pending 2");
    step(1, 1, 2, 9, 0, 0, "R3 read pending 2 as src_b");
    step(0, 2, 2, 2, 0, 0, "R9 idle decode");
    step(0, 0, 0, 0, 1, 2, "R6 writeback 2");
    step(1, 2, 1, 9, 0, 0, "R3 released after wb");
    step(1, 1, 1, 5, 0, 0, "R5 issue dst 5");
    step(1, 5, 1, 10, 1, 5, "R7 same-cycle bypass");
    step(1, 1, 1, 6, 0, 0, "R5 issue dst 6");
    step(1, 1, 3, 6, 0, 0, "R4 waw stall");
    step(0, 0, 0, 0, 1, 6, "R6 writeback 6");
    step(1, 1, 3, 6, 0, 0, "R4 waw released");
    step(1, 1, 1, 7, 1, 7, "R8 issue wins over wb");
    step(1, 1, 1, 0, 0, 0, "R2 dst zero");
    step(0, 0, 0, 0, 1, 0, "R2 wb zero");
    for (int i = 0; i < 400; i++) begin
      logic [3:0] wi;
      logic we;
      wi = 4'($urandom_range(0, 15));
      we = !model[wi] && ($urandom_range(0, 2) != 0);
      step($urandom_range(0, 3) != 0, 4'($urandom_range(0, 15)),
           4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)), we, wi,
           "R3 R4 R5 R6 random");
    end
    step(0, 0, 0, 0, 0, 0, "R6 drain");
    @(posedge clk); #5;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule